// File: doc/BRIEF.md
# Local Multiframe Clock Generator with SYSREF Alignment

This block produces the local multiframe clock for a JESD204B-style receive or transmit link. A phase counter runs on the fabric clock and wraps once per multiframe. On every wrap it raises a one-cycle boundary strobe, and it also presents its current phase. The multiframe length is programmed through a single 32-bit control word. Software sets the length as the cycle count minus one.

An asynchronous SYSREF input passes through a synchronizer and an edge detector. When the sampler is enabled, a rising edge of SYSREF snaps the counter back to phase zero, which aligns the multiframe boundary to the system reference. When the sampler is disabled, the counter keeps running at the programmed length and SYSREF has no effect. This is the state the block is held in while the link core is being reset or brought up.

A sticky flag reports that an alignment has happened since the last write to the control word.

Top module: `lmfc_sysref_gen`

## Requirements
- R1: After reset, the phase is 0, the strobe is low and the seen flag is low. The sampler is disabled and the multiframe length is 20 cycles (field value 19).
- R2: Control bits 31:23 hold the multiframe length minus one. The phase counts 0, 1, ..., field value and then returns to 0, so a field of 0 gives a length of one cycle.
- R3: `lmfc_strobe` is high for exactly the cycles in which the phase has just been returned to 0, whether by a wrap or by an alignment. It is low in all other cycles, including the first cycles after reset.
- R4: Control bit 6 set to 0 enables the sampler. While enabled, suppose SYSREF is first sampled high at clock edge k after having been low. Then after edge k+2 the phase reads 0 and the strobe is high.
- R5: Control bit 6 set to 1 disables the sampler. While disabled, SYSREF has no effect on the phase, the strobe or the seen flag.
- R6: `sysref_seen` is set by each accepted alignment and cleared by any control write. If both happen at the same edge, the flag is set.
- R7: A new length written while the counter runs is used only from the next wrap or alignment onward. The multiframe in progress finishes with the old length.
- R8: SYSREF held high causes only one alignment. A new alignment needs a low period followed by another rising edge.
- R9: Control bits other than 31:23 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_async | input | 1 | SYSREF, asynchronous to clk |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word written when ctl_we is high |
| lmfc_strobe | output | 1 | One-cycle multiframe boundary pulse |
| lmfc_phase | output | 9 | Current phase of the multiframe counter |
| sysref_seen | output | 1 | Sticky flag: an alignment occurred since the last write |

## Verification
A wrong internal state shows up at the ports within one multiframe.

- A length latched at the wrong moment moves the next strobe early or late in the first multiframe after the write.
- A broken synchronizer or edge detector shows up as an alignment landing off the two-cycle latency, as repeated alignments while SYSREF stays high, or as an alignment while the sampler is disabled. The phase and the seen flag expose each of these on the very next clock.
- The reference model is compared against phase, strobe and flag on every cycle. Any divergence is therefore reported in the cycle where it first appears.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;

   localparam int CTL_W = 32;

   typedef enum logic [1:0] {
      PH_STEP  = 2'd0,
      PH_WRAP  = 2'd1,
      PH_ALIGN = 2'd2
   } ph_act_t;

endpackage

// File: rtl/lmfc_ctl_reg.sv
module lmfc_ctl_reg
   import lmfc_pkg::*;
#(
   parameter int LEN_LSB   = 23,
   parameter int LEN_W     = 9,
   parameter int OFF_BIT   = 6,
   parameter int LEN_RESET = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic [LEN_W-1:0] len_field,
   output logic             smp_off
);

   localparam int LEN_MSB = LEN_LSB + LEN_W - 1;

   if (LEN_MSB >= CTL_W) begin : g_len_range_bad
      $error("length field does not fit the control word");
   end
   if (OFF_BIT >= LEN_LSB && OFF_BIT <= LEN_MSB) begin : g_off_overlap_bad
      $error("disable bit overlaps the length field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_field <= LEN_W'(LEN_RESET);
         smp_off   <= 1'b1;
      end else if (we) begin
         len_field <= wdata[LEN_MSB:LEN_LSB];
         smp_off   <= wdata[OFF_BIT];
      end
   end

endmodule

// File: rtl/lmfc_ref_sync.sv
module lmfc_ref_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_async,
   output logic rise
);

   if (STAGES < 2) begin : g_stages_bad
      $error("synchronizer needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din_async};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/lmfc_phase_ctr.sv
module lmfc_phase_ctr
   import lmfc_pkg::*;
#(
   parameter int LEN_W     = 9,
   parameter int LEN_RESET = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] len_cfg,
   input  logic             align,
   output logic [LEN_W-1:0] phase,
   output logic             strobe,
   output logic [LEN_W-1:0] len_act
);

   ph_act_t act;

   always_comb begin
      if (align)                 act = PH_ALIGN;
      else if (phase == len_act) act = PH_WRAP;
      else                       act = PH_STEP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= '0;
         strobe  <= 1'b0;
         len_act <= LEN_W'(LEN_RESET);
      end else begin
         unique case (act)
            PH_ALIGN, PH_WRAP: begin
               phase   <= '0;
               strobe  <= 1'b1;
               len_act <= len_cfg;
            end
            default: begin
               phase  <= phase + 1'b1;
               strobe <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/lmfc_sysref_gen.sv
module lmfc_sysref_gen
   import lmfc_pkg::*;
#(
   parameter int LEN_LSB     = 23,
   parameter int LEN_W       = 9,
   parameter int OFF_BIT     = 6,
   parameter int DEF_CYCLES  = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sysref_async,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic             lmfc_strobe,
   output logic [LEN_W-1:0] lmfc_phase,
   output logic             sysref_seen
);

   localparam int LEN_RESET = DEF_CYCLES - 1;

   if (DEF_CYCLES < 1 || LEN_RESET >= (1 << LEN_W)) begin : g_def_bad
      $error("default length does not fit the length field");
   end

   logic [LEN_W-1:0] len_cfg;
   logic [LEN_W-1:0] len_act;
   logic             smp_off;
   logic             ref_rise;
   logic             cap_ok;

   lmfc_ctl_reg #(
      .LEN_LSB  (LEN_LSB),
      .LEN_W    (LEN_W),
      .OFF_BIT  (OFF_BIT),
      .LEN_RESET(LEN_RESET)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctl_we),
      .wdata    (ctl_wdata),
      .len_field(len_cfg),
      .smp_off  (smp_off)
   );

   lmfc_ref_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din_async(sysref_async),
      .rise     (ref_rise)
   );

   assign cap_ok = ref_rise & ~smp_off;

   lmfc_phase_ctr #(
      .LEN_W    (LEN_W),
      .LEN_RESET(LEN_RESET)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .len_cfg(len_cfg),
      .align  (cap_ok),
      .phase  (lmfc_phase),
      .strobe (lmfc_strobe),
      .len_act(len_act)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      sysref_seen <= 1'b0;
      else if (cap_ok) sysref_seen <= 1'b1;
      else if (ctl_we) sysref_seen <= 1'b0;
   end

endmodule

// File: rtl/lmfc_sysref_gen_chk.sv
module lmfc_sysref_gen_chk #(
   parameter int LEN_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic             lmfc_strobe,
   input logic [LEN_W-1:0] lmfc_phase,
   input logic             sysref_seen,
   input logic             cap_ok,
   input logic             smp_off,
   input logic [LEN_W-1:0] len_act
);

   AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lmfc_strobe |-> (lmfc_phase == '0)); // R3

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lmfc_strobe || lmfc_phase == $past(lmfc_phase) + 1'b1)); // R2

   AST_WRAP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (lmfc_phase == len_act) |=> lmfc_strobe); // R7

   AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lmfc_strobe || $stable(len_act))); // R7

   AST_OFF_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_off && lmfc_phase != len_act) |=> (lmfc_phase == $past(lmfc_phase) + 1'b1)); // R5

   AST_ALIGN_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ok |=> (lmfc_phase == '0 && lmfc_strobe && sysref_seen)); // R4

   AST_SEEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !cap_ok) |=> !sysref_seen); // R6

   AST_SEEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !cap_ok) |=> $stable(sysref_seen)); // R6

endmodule

bind lmfc_sysref_gen lmfc_sysref_gen_chk #(
   .LEN_W(LEN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_we     (ctl_we),
   .lmfc_strobe(lmfc_strobe),
   .lmfc_phase (lmfc_phase),
   .sysref_seen(sysref_seen),
   .cap_ok     (cap_ok),
   .smp_off    (smp_off),
   .len_act    (len_act)
);

// File: tb/lmfc_sysref_gen_test.sv
`timescale 1ns/1ps
module lmfc_sysref_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sysref_async = 1'b0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        lmfc_strobe;
   logic [8:0]  lmfc_phase;
   logic        sysref_seen;

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit cur_sr = 0;

   always #2.5 clk = ~clk;

   lmfc_sysref_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sysref_async(sysref_async),
      .ctl_we      (ctl_we),
      .ctl_wdata   (ctl_wdata),
      .lmfc_strobe (lmfc_strobe),
      .lmfc_phase  (lmfc_phase),
      .sysref_seen (sysref_seen)
   );

   // Behavioural reference: expected outputs after each rising edge.
   int m_len_cfg, m_len_cur, m_off, m_ph, m_st, m_seen;
   int hist[$];   // past SYSREF samples, newest at index 0

   always @(posedge clk) begin
      if (!rst_n) begin
         m_len_cfg = 19; m_len_cur = 19; m_off = 1;
         m_ph = 0; m_st = 0; m_seen = 0;
         hist = '{0, 0, 0};
      end else begin
         bit hit;
         hit = (hist[1] == 1) && (hist[2] == 0) && (m_off == 0);
         if (hit || m_ph == m_len_cur) begin
            m_ph = 0; m_st = 1; m_len_cur = m_len_cfg;
         end else begin
            m_ph = m_ph + 1; m_st = 0;
         end
         if (hit) m_seen = 1;
         else if (ctl_we) m_seen = 0;
         if (ctl_we) begin
            m_len_cfg = int'(ctl_wdata[31:23]);
            m_off = int'(ctl_wdata[6]);
         end
         hist.push_front(int'(sysref_async));
         void'(hist.pop_back());
      end
   end

   task automatic compare(input string tag);
      total++;
      if (int'(lmfc_phase) != m_ph) begin
         bad++;
         $display("FAIL %s/R2 phase actual=%0d expected=%0d", tag, lmfc_phase, m_ph);
      end
      total++;
      if (int'(lmfc_strobe) != m_st) begin
         bad++;
         $display("FAIL %s/R3 strobe actual=%0d expected=%0d", tag, lmfc_strobe, m_st);
      end
      total++;
      if (int'(sysref_seen) != m_seen) begin
         bad++;
         $display("FAIL %s/R6 seen actual=%0d expected=%0d", tag, sysref_seen, m_seen);
      end
   endtask

   task automatic cyc(input bit we, input logic [31:0] d, input string tag);
      @(negedge clk);
      compare(tag);
      ctl_we = we;
      ctl_wdata = d;
      sysref_async = cur_sr;
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 32'h0, tag);
   endtask

   function automatic logic [31:0] word(input int len_m1, input bit off);
      return (32'(len_m1) << 23) | (32'(off) << 6);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (4) begin
         @(negedge clk);
         compare("R1");
      end
      rst_n = 1'b1;
      run(3, "R1");
      // R2: default 20-cycle multiframe, sampler disabled
      run(45, "R2");
      // R5: SYSREF toggled while disabled
      cur_sr = 1; run(5, "R5");
      cur_sr = 0; run(10, "R5");
      // R9: enable with noise in unrelated bits
      cyc(1'b1, word(19, 1'b0) | 32'h007F_FF3F, "R9");
      run(7, "R9");
      // R4: rising SYSREF realigns
      cur_sr = 1; run(3, "R4");
      // R8: held high, no further alignment
      run(30, "R8");
      cur_sr = 0; run(5, "R8");
      // R6: write clears seen
      cyc(1'b1, word(19, 1'b0), "R6");
      run(5, "R6");
      // R7: shorter length written mid-multiframe
      cyc(1'b1, word(7, 1'b0), "R7");
      run(40, "R7");
      // R2: one-cycle multiframe
      cyc(1'b1, word(0, 1'b0), "R2");
      run(6, "R2");
      // R6: write and alignment at the same edge
      cyc(1'b1, word(11, 1'b0), "R6");
      cur_sr = 1;
      for (int i = 0; i < 6; i++) cyc(1'b1, word(11, 1'b0), "R6");
      cur_sr = 0;
      run(30, "R6");
      // R4: second rising edge after a low gap
      cur_sr = 1; run(4, "R4");
      cur_sr = 0; run(20, "R4");
      // R5: disable again and pulse SYSREF
      cyc(1'b1, word(11, 1'b1), "R5");
      cur_sr = 1; run(10, "R5");
      cur_sr = 0; run(20, "R5");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule